// File: doc/BRIEF.md
# Grouped Tick Counters with Compare Interrupt

This block holds three 64-bit timer units that run side by side: a core tick, a system tick and a hypervisor system tick. Each unit has a free-running count and a compare limit. When an enabled tick moves the count onto the limit, the unit raises a one-shot compare event. The event sets a bit in a small soft-interrupt register. The core tick drives its own timer bit. The two system-tick units share a second bit, the system-timer bit.

The top bit of each register is a control flag, not part of the value. In the count word it is a flag that traps non-privileged reads. In the limit word it is an interrupt-disable flag. A limit of zero, or a set disable flag, cancels the pending compare.

A limit written at or below the count it is compared against is not lost. Instead, it fires on the unit's next enabled tick. Software reaches all six registers through one write port and one combinational read port. It clears soft-interrupt bits with a clear strobe.

Top module: `tick_cmp_group`

## Requirements
- R1: A count write (`wr_reg`=0) loads `wr_data[62:0]` into the selected count and keeps `wr_data[63]` as its trap flag. A count write made in the same cycle as a tick of that unit wins, and the count does not step.
- R2: Reading a count (`rd_reg`=0) returns the trap flag in bit 63 and the count in bits 62:0. The count rises by one on each clock edge where the unit's `tick_en` bit is 1. It wraps from 2^63-1 to 0, and it holds while `tick_en` is 0.
- R3: A limit write (`wr_reg`=1) stores `wr_data[62:0]` as the compare value and `wr_data[63]` as the disable flag. Reading the limit returns both in the same positions.
- R4: A limit written with compare value zero produces no interrupt.
- R5: A limit written with bit 63 set produces no interrupt.
- R6: An armed unit fires on the edge where an enabled tick makes the count equal the compare value. The soft-interrupt bit is visible right after that edge. The unit fires once per limit write.
- R7: A limit whose value is not above the count holding after the write cycle fires on the unit's next enabled tick.
- R8: Unit 0 (core tick) sets `softint[0]`. Units 1 and 2 (system and hypervisor tick) set `softint[1]`. `irq_pend` is the OR of `softint`.
- R9: Soft-interrupt bits stay set until the matching `si_clr` bit is 1 at an edge. A set in the same cycle as a clear wins.
- R10: After reset, each count reads 0 with the trap flag at 1, each limit reads 0 with the disable flag at 1, `softint` is 0 and no compare is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 3 | Per-unit tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Unit written (0..2) |
| wr_reg | input | 1 | 0 = count, 1 = limit |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Unit read (3 reads zero) |
| rd_reg | input | 1 | 0 = count, 1 = limit |
| rd_data | output | 64 | Read data |
| si_clr | input | 2 | Soft-interrupt clear strobes |
| softint | output | 2 | Bit 0 timer, bit 1 system timer |
| irq_pend | output | 1 | Any soft-interrupt bit set |

## Verification
A wrong count or flag shows on `rd_data` in the cycle right after the edge that corrupted it. A wrong armed or late state stays hidden until the unit's next enabled tick. At that tick, `softint` either rises when it should not or stays low when it should rise, so the error shows one edge later. The bench compares every port each cycle against a model built from the requirements. It also walks the wrap, a late limit, a zero limit, a disabled limit, a write/tick collision and a set/clear collision.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int WORD_W  = 64;
  localparam int VAL_W   = WORD_W - 1;
  localparam int N_UNITS = 3;
  localparam int SI_W    = 2;

  typedef logic [VAL_W-1:0] tval_t;

  function automatic logic [WORD_W-1:0] pack_word(input logic flag, input tval_t v);
    return {flag, v};
  endfunction

  function automatic logic limit_is_late(input tval_t lim, input tval_t cnt_after);
    return lim <= cnt_after;
  endfunction

  function automatic int si_bit_of(input int unit);
    return (unit == 0) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tick_unit.sv
module tick_unit
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_we,
  input  logic              lim_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cnt_word,
  output logic [WORD_W-1:0] lim_word,
  output logic              fire
);
  tval_t cnt_q, lim_q, cnt_inc, cnt_nxt, wval;
  logic  trap_q, dis_q, armed_q, late_q;
  logic  hit_eq;

  assign wval    = wdata[VAL_W-1:0];
  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_nxt = cnt_we ? wval : (tick ? cnt_inc : cnt_q);
  assign hit_eq  = (cnt_inc == lim_q);
  assign fire    = tick && !cnt_we && !lim_we && armed_q && (late_q || hit_eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trap_q  <= 1'b1;
      lim_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (cnt_we) trap_q <= wdata[WORD_W-1];
      if (lim_we) begin
        lim_q   <= wval;
        dis_q   <= wdata[WORD_W-1];
        armed_q <= (wval != '0) && !wdata[WORD_W-1];
        late_q  <= limit_is_late(wval, cnt_nxt);
      end else if (fire) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign cnt_word = pack_word(trap_q, cnt_q);
  assign lim_word = pack_word(dis_q, lim_q);

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wval)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && tick) |=> cnt_q == $past(cnt_inc)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && !tick) |=> $stable(cnt_q)); // R2
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) |-> !fire); // R4
  AST_DIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !fire); // R5
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R6
endmodule

// File: rtl/softint_reg.sv
module softint_reg
  import tick_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SI_W-1:0] set,
  input  logic [SI_W-1:0] clr,
  output logic [SI_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  for (genvar b = 0; b < SI_W; b++) begin : g_chk
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set[b] |=> q[b]); // R9
    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (q[b] && !clr[b]) |=> q[b]); // R9
  end
endmodule

// File: rtl/tick_cmp_group.sv
module tick_cmp_group
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        tick_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_reg,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  input  logic              rd_reg,
  output logic [WORD_W-1:0] rd_data,
  input  logic [SI_W-1:0]   si_clr,
  output logic [SI_W-1:0]   softint,
  output logic              irq_pend
);
  logic [N_UNITS-1:0]   fire;
  logic [WORD_W-1:0]    cnt_w [N_UNITS];
  logic [WORD_W-1:0]    lim_w [N_UNITS];
  logic [SI_W-1:0]      si_set;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic sel;
    assign sel = wr_en && (wr_sel == u[1:0]);
    tick_unit u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en[u]),
      .cnt_we   (sel && !wr_reg),
      .lim_we   (sel && wr_reg),
      .wdata    (wr_data),
      .cnt_word (cnt_w[u]),
      .lim_word (lim_w[u]),
      .fire     (fire[u])
    );
  end

  always_comb begin
    si_set = '0;
    for (int u = 0; u < N_UNITS; u++)
      if (fire[u]) si_set[si_bit_of(u)] = 1'b1;
  end

  always_comb begin
    rd_data = '0;
    for (int u = 0; u < N_UNITS; u++)
      if (rd_sel == u[1:0]) rd_data = rd_reg ? lim_w[u] : cnt_w[u];
  end

  softint_reg u_si (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (si_set),
    .clr   (si_clr),
    .q     (softint)
  );

  assign irq_pend = |softint;

  AST_CORE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire[0] |=> softint[0]); // R8
  AST_SYS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[1] || fire[2]) |=> softint[1]); // R8
endmodule

// File: tb/tick_cmp_group_bench.sv
module tick_cmp_group_bench;
  logic clk = 0, rst_n = 0;
  logic [2:0] tick_en = 0;
  logic wr_en = 0, wr_reg = 0, rd_reg = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0, si_clr = 0, softint;
  logic [63:0] wr_data = 0, rd_data;
  logic irq_pend;
  int checks = 0, fails = 0;

  logic [62:0] m_cnt [3], m_lim [3];
  logic m_trap [3], m_dis [3], m_arm [3], m_late [3];
  logic [1:0] m_si;

  always #5 clk = ~clk;

  tick_cmp_group u_tick_cmp_group (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int u = 0; u < 3; u++) begin
      m_cnt[u] = 0; m_lim[u] = 0; m_trap[u] = 1; m_dis[u] = 1;
      m_arm[u] = 0; m_late[u] = 0;
    end
    m_si = 0;
  endtask

  task automatic model_step();
    logic [1:0] set = 0;
    for (int u = 0; u < 3; u++) begin
      logic cw, lw, hit;
      logic [62:0] nxt;
      cw = wr_en && wr_sel == u && !wr_reg;
      lw = wr_en && wr_sel == u && wr_reg;
      nxt = cw ? wr_data[62:0] : (tick_en[u] ? m_cnt[u] + 63'd1 : m_cnt[u]);
      hit = tick_en[u] && !cw && !lw && m_arm[u] &&
            (m_late[u] || (m_cnt[u] + 63'd1 == m_lim[u]));
      if (hit) set[u == 0 ? 0 : 1] = 1;
      if (cw) m_trap[u] = wr_data[63];
      if (lw) begin
        m_lim[u] = wr_data[62:0]; m_dis[u] = wr_data[63];
        m_arm[u] = (wr_data[62:0] != 0) && !wr_data[63];
        m_late[u] = !(wr_data[62:0] > nxt);
      end else if (hit) m_arm[u] = 0;
      m_cnt[u] = nxt;
    end
    m_si = (m_si & ~si_clr) | set;
  endtask

  function automatic logic [63:0] exp_rd();
    if (rd_sel == 3) return 0;
    return rd_reg ? {m_dis[rd_sel], m_lim[rd_sel]} : {m_trap[rd_sel], m_cnt[rd_sel]};
  endfunction

  task automatic cyc(string req);
    @(posedge clk);
    model_step();
    #1;
    chk(req, {62'd0, softint}, {62'd0, m_si});
    chk("R8", {63'd0, irq_pend}, {63'd0, |m_si});
    chk(req, rd_data, exp_rd());
    @(negedge clk);
    wr_en = 0; tick_en = 0; si_clr = 0;
  endtask

  task automatic wr(int u, logic r, logic [63:0] d);
    wr_en = 1; wr_sel = u[1:0]; wr_reg = r; wr_data = d;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
    model_reset();
    #12;
    for (int u = 0; u < 3; u++) begin
      rd_sel = u[1:0]; rd_reg = 0; #1;
      chk("R10", rd_data, {1'b1, 63'd0});
      rd_reg = 1; #1;
      chk("R10", rd_data, {1'b1, 63'd0});
    end
    chk("R10", {62'd0, softint}, 0);
    @(negedge clk); rst_n = 1;

    // R2 wrap and count read
    rd_sel = 0; rd_reg = 0;
    wr(0, 0, {1'b0, {63{1'b1}}}); cyc("R1");
    tick_en = 3'b001; cyc("R2");
    chk("R2", rd_data, 64'd0);
    // R1 write beats tick
    wr(0, 0, {1'b1, 63'd40}); tick_en = 3'b001; cyc("R1");
    chk("R1", rd_data, {1'b1, 63'd40});
    // R6 exact match on unit 0
    rd_reg = 1; wr(0, 1, 64'd42); cyc("R3");
    tick_en = 1; cyc("R6");
    tick_en = 1; cyc("R6");
    chk("R6", {62'd0, softint}, 2'b01);
    // R9 set wins over clear is covered in random; clear here
    si_clr = 2'b01; cyc("R9");
    chk("R9", {62'd0, softint}, 0);
    // R7 late limit on unit 1
    rd_sel = 1; wr(1, 0, 64'd100); cyc("R1");
    wr(1, 1, 64'd5); cyc("R3");
    chk("R7", {62'd0, softint}, 0);
    tick_en = 3'b010; cyc("R7");
    chk("R7", {62'd0, softint}, 2'b10);
    // R4 zero limit, R5 disabled limit on unit 2
    si_clr = 2'b11; cyc("R9");
    rd_sel = 2; wr(2, 0, 64'd0); cyc("R1");
    wr(2, 1, 64'd0); cyc("R4");
    for (int i = 0; i < 3; i++) begin tick_en = 3'b100; cyc("R4"); end
    chk("R4", {62'd0, softint}, 0);
    wr(2, 1, {1'b1, 63'd6}); cyc("R5");
    for (int i = 0; i < 4; i++) begin tick_en = 3'b100; cyc("R5"); end
    chk("R5", {62'd0, softint}, 0);
    // R8 hypervisor unit maps to bit 1
    wr(2, 1, 64'd10); cyc("R3");
    for (int i = 0; i < 3; i++) begin tick_en = 3'b100; cyc("R8"); end
    chk("R8", {62'd0, softint}, 2'b10);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int u = $urandom_range(0, 2);
      tick_en = 3'($urandom);
      si_clr  = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      rd_sel  = 2'($urandom); rd_reg = 1'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        logic r = 1'($urandom);
        logic [62:0] v = r ? m_cnt[u] + 63'($urandom_range(0, 6)) - 63'd2
                           : 63'($urandom_range(0, 50));
        if ($urandom_range(0, 15) == 0) v = 0;
        wr(u, r, {($urandom_range(0, 5) == 0), v});
      end
      cyc("R6");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule